// File: doc/BRIEF.md
# Four-Channel 16-bit DAC Register Target on I2C

This block is the digital bus front end of a converter with four 16-bit channels. It watches an I2C bus through oversampled copies of SCL and SDA. It acknowledges its 7-bit bus address and then interprets a control byte. It holds a staging (temporary) word and a live output word per channel, and a two-bit power-down mode per channel. The live words and the power-down modes are presented on wide output buses for the analog side.

The 7-bit bus address carries only the two low strap pins. The two high strap pins are instead compared against the top two bits of the control byte, so up to sixteen targets can share one bus. A write frame carries the control byte and then a 16-bit word, most significant byte first. The control byte's load mode picks one of four behaviours: stage only, stage and update one channel, stage and then update every channel from staging, or update every channel regardless of the high strap pins. A read frame repeats the start after the control byte and then returns the live word of the chosen channel. When the control byte's power-down flag is set, a status byte comes before that word.

SDA is never driven high. The block only asserts `sdaOe`, which pulls the wire low.

Top module: `qdac_i2c_target`

## Requirements
- R1: After the active-low reset, every channel's output word is 0x0000, every power-down mode is 00, and `sdaOe` is low.
- R2: The target pulls SDA low in the acknowledge slot of an address byte only when its upper seven bits equal {1,0,0,1,1,A1,A0}, with A1 = `addrPins[1]` and A0 = `addrPins[0]`. It never starts pulling SDA low while synchronized SCL is high.
- R3: The control byte is laid out as bit 7..6 = {A3,A2}, bits 5..4 = load mode, bit 3 ignored, bits 2..1 = channel (0 to 3), bit 0 = power-down flag. Load mode 00 stores the word in the chosen channel's staging register only, so no output word changes.
- R4: Load mode 01 writes the word into both the staging register and the output word of the chosen channel, once the least significant byte has been received.
- R5: Load mode 10 first stores the word into the chosen channel's staging register. It then copies all four staging registers into the four output words at the same time.
- R6: Load mode 11 writes the word into the staging and output registers of all four channels, whatever the control byte's A3/A2 bits and the `addrPins[3:2]` pins are.
- R7: A write whose control-byte bits 7..6 differ from `addrPins[3:2]`, with a load mode other than 11, is acknowledged byte by byte but changes no register.
- R8: With the power-down flag at 0, a read returns two bytes: the most significant and then the least significant byte of the chosen channel's output word, whatever the load mode bits are. A staged value is never returned.
- R9: With the power-down flag at 1, a read returns three bytes. The first is {mode[1:0], 6'b111111}, so mode 00 gives 0x3F and mode 10 gives 0xBF. The output word follows.
- R10: A write with the power-down flag at 1 stores bits 7..6 of the most significant byte as the chosen channel's power-down mode, or as the mode of all channels under load mode 11, and leaves all data words unchanged.
- R11: During a read whose stored control byte fails the A3/A2 check, with a load mode other than 11, the target never pulls SDA low after the address acknowledge, so the controller reads 0xFF.
- R12: A stop condition that arrives before the least significant byte ends the write with no register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| addrPins | input | 4 | Strap pins {A3,A2,A1,A0} |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| dacCodes | output | 64 | Output words, channel n at bits [16n+15:16n] |
| pdModes | output | 8 | Power-down modes, channel n at bits [2n+1:2n] |

## Verification
The hardest situation to reach is a read whose control byte fails the high-address check. The address byte itself matches, so the target still acknowledges it, and only the data bits must stay released. The stimulus writes a control byte carrying the wrong A3/A2 bits, issues a repeated start with the read address, and then checks that all three returned bytes read as 0xFF while the address acknowledge still arrives. A second hard case is a write frame cut off by a stop before its last byte. The bench drives that frame on purpose and then compares every output word.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NCH   = 4;
  localparam int CHW   = $clog2(NCH);
  localparam int DW    = 16;
  localparam int PDW   = 2;

  localparam logic [1:0] LD_STAGE  = 2'b00;
  localparam logic [1:0] LD_DIRECT = 2'b01;
  localparam logic [1:0] LD_SWEEP  = 2'b10;
  localparam logic [1:0] LD_BCAST  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CTRL, ST_MSB, ST_LSB, ST_TX, ST_WAIT
  } busState_t;

  typedef struct packed {
    logic       ctrlLoad;
    logic       msbLoad;
    logic       commit;
    logic [7:0] rxByte;
  } strobes_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
#(
  parameter logic [4:0] BASE_ADDR = 5'b10011
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] addrLow,
  input  logic [7:0] txByte,
  input  logic       drvEn,
  output strobes_t   strb,
  output logic [1:0] txIdx,
  output logic       sdaOe,
  output logic       sclSync,
  output busState_t  busState
);
  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       startDet, stopDet, sclRise, sclFall;
  logic       byteDone, ackDone, addrHit;
  logic [3:0] bitCnt;
  logic [7:0] rxSh, txSh;

  // two-flop synchronizers plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end

  assign sclS     = sclPipe[1];
  assign sdaS     = sdaPipe[1];
  assign sclSync  = sclS;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign byteDone = sclFall && (bitCnt == 4'd8);
  assign ackDone  = sclFall && (bitCnt == 4'd9);
  assign addrHit  = (rxSh[7:1] == {BASE_ADDR, addrLow});

  always_comb begin
    strb.ctrlLoad = byteDone && (busState == ST_CTRL);
    strb.msbLoad  = byteDone && (busState == ST_MSB);
    strb.commit   = byteDone && (busState == ST_LSB);
    strb.rxByte   = rxSh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState <= ST_IDLE;
      bitCnt   <= '0;
      rxSh     <= '0;
      txSh     <= '0;
      txIdx    <= '0;
      sdaOe    <= 1'b0;
    end else if (startDet) begin
      busState <= ST_ADDR;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
    end else if (stopDet) begin
      busState <= ST_IDLE;
      bitCnt   <= '0;
      sdaOe    <= 1'b0;
    end else begin
      unique case (busState)
        ST_IDLE: ;
        ST_WAIT: begin
          if (ackDone) sdaOe <= 1'b0;
        end
        ST_TX: begin
          if (sclRise) begin
            if (bitCnt < 4'd8) bitCnt <= bitCnt + 4'd1;
            else if (bitCnt == 4'd8) begin
              if (sdaS) busState <= ST_WAIT;   // controller NACK ends the read
              else      bitCnt   <= 4'd9;
            end
          end else if (sclFall) begin
            if (bitCnt == 4'd9) begin
              txSh   <= txByte;
              sdaOe  <= drvEn & ~txByte[7];
              txIdx  <= (txIdx == 2'd3) ? 2'd3 : txIdx + 2'd1;
              bitCnt <= '0;
            end else if (bitCnt == 4'd8) begin
              sdaOe <= 1'b0;
            end else if (bitCnt != 4'd0) begin
              sdaOe <= drvEn & ~txSh[6];
              txSh  <= {txSh[6:0], 1'b1};
            end
          end
        end
        default: begin
          if (sclRise && (bitCnt < 4'd8)) begin
            rxSh   <= {rxSh[6:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCnt <= 4'd9;
            unique case (busState)
              ST_ADDR: begin
                if (addrHit) begin
                  sdaOe    <= 1'b1;
                  txIdx    <= '0;
                  busState <= rxSh[0] ? ST_TX : ST_CTRL;
                end else begin
                  busState <= ST_WAIT;
                end
              end
              ST_CTRL: begin sdaOe <= 1'b1; busState <= ST_MSB;  end
              ST_MSB:  begin sdaOe <= 1'b1; busState <= ST_LSB;  end
              default: begin sdaOe <= 1'b1; busState <= ST_WAIT; end
            endcase
          end else if (ackDone) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/qdac_dpath.sv
module qdac_dpath
  import qdac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         addrHigh,
  input  strobes_t           strb,
  input  logic [1:0]         txIdx,
  output logic [7:0]         txByte,
  output logic               drvEn,
  output logic               match,
  output logic [NCH*DW-1:0]  dacCodes,
  output logic [NCH*PDW-1:0] pdModes
);
  logic [7:0]     ctrlReg, msbReg;
  logic [DW-1:0]  stageReg [NCH];
  logic [DW-1:0]  liveReg  [NCH];
  logic [PDW-1:0] pdReg    [NCH];
  logic [CHW-1:0] sel;
  logic [1:0]     mode;
  logic           pdFlag;
  logic [DW-1:0]  newWord;
  logic [2:0]     effIdx;

  assign sel     = ctrlReg[2:1];
  assign mode    = ctrlReg[5:4];
  assign pdFlag  = ctrlReg[0];
  assign match   = (ctrlReg[7:6] == addrHigh) || (mode == LD_BCAST);
  assign newWord = {msbReg, strb.rxByte};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      msbReg  <= '0;
      for (int ch = 0; ch < NCH; ch++) begin
        stageReg[ch] <= '0;
        liveReg[ch]  <= '0;
        pdReg[ch]    <= '0;
      end
    end else begin
      if (strb.ctrlLoad) ctrlReg <= strb.rxByte;
      if (strb.msbLoad)  msbReg  <= strb.rxByte;
      if (strb.commit && match) begin
        for (int ch = 0; ch < NCH; ch++) begin
          if (pdFlag) begin
            if (mode == LD_BCAST || CHW'(ch) == sel) pdReg[ch] <= msbReg[7:6];
          end else begin
            unique case (mode)
              LD_STAGE: begin
                if (CHW'(ch) == sel) stageReg[ch] <= newWord;
              end
              LD_DIRECT: begin
                if (CHW'(ch) == sel) begin
                  stageReg[ch] <= newWord;
                  liveReg[ch]  <= newWord;
                end
              end
              LD_SWEEP: begin
                if (CHW'(ch) == sel) begin
                  stageReg[ch] <= newWord;
                  liveReg[ch]  <= newWord;
                end else begin
                  liveReg[ch]  <= stageReg[ch];
                end
              end
              default: begin
                stageReg[ch] <= newWord;
                liveReg[ch]  <= newWord;
              end
            endcase
          end
        end
      end
    end
  end

  // read byte order: optional status byte, then high and low halves
  assign effIdx = {1'b0, txIdx} + {2'b00, ~pdFlag};
  always_comb begin
    unique case (effIdx)
      3'd0:    txByte = {pdReg[sel], 6'b111111};
      3'd1:    txByte = liveReg[sel][15:8];
      3'd2:    txByte = liveReg[sel][7:0];
      default: txByte = 8'hFF;
    endcase
  end
  assign drvEn = match;

  for (genvar g = 0; g < NCH; g++) begin : g_pack
    assign dacCodes[g*DW +: DW]  = liveReg[g];
    assign pdModes[g*PDW +: PDW] = pdReg[g];
  end
endmodule

// File: rtl/qdac_i2c_target.sv
module qdac_i2c_target
  import qdac_pkg::*;
#(
  parameter logic [4:0] BASE_ADDR = 5'b10011
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [3:0]         addrPins,
  output logic               sdaOe,
  output logic [NCH*DW-1:0]  dacCodes,
  output logic [NCH*PDW-1:0] pdModes
);
  strobes_t   strb;
  logic [1:0] txIdx;
  logic [7:0] txByte;
  logic       drvEn, match, sclSync;
  busState_t  busState;

  qdac_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrLow(addrPins[1:0]), .txByte(txByte), .drvEn(drvEn),
    .strb(strb), .txIdx(txIdx), .sdaOe(sdaOe), .sclSync(sclSync),
    .busState(busState)
  );

  qdac_dpath u_dpath (
    .clk(clk), .rstN(rstN), .addrHigh(addrPins[3:2]), .strb(strb),
    .txIdx(txIdx), .txByte(txByte), .drvEn(drvEn), .match(match),
    .dacCodes(dacCodes), .pdModes(pdModes)
  );
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
  import qdac_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               sclSync,
  input logic               sdaOe,
  input busState_t          busState,
  input logic               drvEn,
  input strobes_t           strb,
  input logic               match,
  input logic [NCH*DW-1:0]  dacCodes,
  input logic [NCH*PDW-1:0] pdModes
);
  // R2: the target only begins pulling SDA low while SCL is low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclSync);

  // R3: output words move only after a completed write frame
  p_hold_outputs_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dacCodes) && $stable(pdModes));

  // R7: a frame failing the high-address check leaves everything alone
  p_foreign_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !match) |=> $stable(dacCodes) && $stable(pdModes));

  // R11: data bits of a rejected read never pull the wire
  p_quiet_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) && busState == ST_TX && $past(busState) == ST_TX) |-> drvEn);
endmodule

bind qdac_i2c_target qdac_checker u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaOe(sdaOe),
  .busState(busState), .drvEn(drvEn), .strb(strb), .match(match),
  .dacCodes(dacCodes), .pdModes(pdModes)
);

// File: tb/sim_qdac_i2c_target.sv
module sim_qdac_i2c_target;
  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1;
  logic [3:0] pins = 4'b0100;   // A3=0 A2=1 A1=0 A0=0
  logic sdaOe;
  logic [63:0] codes;
  logic [7:0] pds;
  wire sdaLine = sdaM & ~sdaOe;

  always #10 clk = ~clk;   // 50 MHz

  qdac_i2c_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrPins(pins),
    .sdaOe(sdaOe), .dacCodes(codes), .pdModes(pds)
  );

  typedef struct { int req; int val; } item_t;
  item_t expQ[$];
  item_t actQ[$];
  item_t eItem, aItem;
  int checks = 0, errors = 0;
  bit done = 0;

  // driver side: expected and observed values enter the scoreboard together
  task automatic pushCheck(input int req, input int expV, input int actV);
    expQ.push_back('{req, expV});
    actQ.push_back('{req, actV});
  endtask

  // monitor: drains the scoreboard as results appear
  initial forever begin
    @(negedge clk);
    while (actQ.size() > 0 && expQ.size() > 0) begin
      eItem = expQ.pop_front();
      aItem = actQ.pop_front();
      checks++;
      if (eItem.val != aItem.val) begin
        errors++;
        $display("FAIL R%0d: actual %0h expected %0h", eItem.req, aItem.val, eItem.val);
      end
    end
  end

  task automatic waitQ; repeat (10) @(negedge clk); endtask
  task automatic settle; repeat (8) @(negedge clk); endtask

  task automatic i2cStart;
    sdaM = 1; waitQ; sclM = 1; waitQ; sdaM = 0; waitQ; sclM = 0; waitQ;
  endtask
  task automatic i2cStop;
    sdaM = 0; waitQ; sclM = 1; waitQ; sdaM = 1; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ; sclM = 1; waitQ; waitQ; sclM = 0; waitQ;
    end
    sdaM = 1; waitQ; sclM = 1; waitQ; ack = sdaLine; waitQ; sclM = 0; waitQ;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1; waitQ; sclM = 1; waitQ; b[i] = sdaLine; waitQ; sclM = 0; waitQ;
    end
    sdaM = nack; waitQ; sclM = 1; waitQ; waitQ; sclM = 0; waitQ; sdaM = 1;
  endtask

  function automatic logic [7:0] cb(input logic [1:0] hi, input logic [1:0] md,
                                    input logic [1:0] ch, input logic pd);
    return {hi, md, 1'b0, ch, pd};
  endfunction

  task automatic writeFrame(input logic [7:0] ctl, input logic [15:0] w, output logic anyNack);
    logic a0, a1, a2, a3;
    i2cStart;
    sendByte(8'h98, a0);
    pushCheck(2, 0, int'(a0));   // R2 address acknowledged
    sendByte(ctl, a1); sendByte(w[15:8], a2); sendByte(w[7:0], a3);
    i2cStop;
    anyNack = a1 | a2 | a3;
    settle;
  endtask

  task automatic readFrame(input logic [7:0] ctl, input int n,
                           output logic [7:0] b0, output logic [7:0] b1, output logic [7:0] b2);
    logic a;
    i2cStart; sendByte(8'h98, a); sendByte(ctl, a);
    i2cStart; sendByte(8'h99, a);
    pushCheck(2, 0, int'(a));   // R2 read address acknowledged
    b2 = 8'h00;
    recvByte(1'b0, b0);
    recvByte(n == 2, b1);
    if (n == 3) recvByte(1'b1, b2);
    i2cStop;
    settle;
  endtask

  function automatic int code(input int ch); return int'(codes[ch*16 +: 16]); endfunction
  function automatic int pdm(input int ch);  return int'(pds[ch*2 +: 2]);     endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R0: watchdog actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic nk, ak;
    logic [7:0] r0, r1, r2;
    repeat (5) @(negedge clk);
    rstN = 1;
    settle;
    // R1 reset state
    for (int ch = 0; ch < 4; ch++) begin
      pushCheck(1, 0, code(ch));
      pushCheck(1, 0, pdm(ch));
    end
    pushCheck(1, 0, int'(sdaOe));

    // R2 foreign address: no acknowledge
    i2cStart; sendByte(8'h9A, ak); i2cStop; settle;
    pushCheck(2, 1, int'(ak));

    // R4 direct update of channel 1
    writeFrame(cb(2'b01, 2'b01, 2'd1, 1'b0), 16'h1234, nk);
    pushCheck(4, 16'h1234, code(1));
    pushCheck(4, 0, code(0));

    // R3 staging only on channel 2
    writeFrame(cb(2'b01, 2'b00, 2'd2, 1'b0), 16'hABCD, nk);
    pushCheck(3, 0, code(2));
    // R8 staged word is not what a read returns
    readFrame(cb(2'b01, 2'b00, 2'd2, 1'b0), 2, r0, r1, r2);
    pushCheck(8, 0, int'({r0, r1}));

    // R5 sweep: stage channel 0, then all live words take staging
    writeFrame(cb(2'b01, 2'b10, 2'd0, 1'b0), 16'h5555, nk);
    pushCheck(5, 16'h5555, code(0));
    pushCheck(5, 16'h1234, code(1));
    pushCheck(5, 16'hABCD, code(2));
    pushCheck(5, 0, code(3));

    // R7 wrong high address bits: acknowledged, no effect
    writeFrame(cb(2'b10, 2'b01, 2'd3, 1'b0), 16'h7777, nk);
    pushCheck(7, 0, int'(nk));
    pushCheck(7, 0, code(3));

    // R6 broadcast ignores the high address bits
    writeFrame(cb(2'b10, 2'b11, 2'd0, 1'b0), 16'h0F0F, nk);
    for (int ch = 0; ch < 4; ch++) pushCheck(6, 16'h0F0F, code(ch));

    // R10 power-down write to channel 1
    writeFrame(cb(2'b01, 2'b01, 2'd1, 1'b1), 16'h8000, nk);
    pushCheck(10, 2, pdm(1));
    pushCheck(10, 0, pdm(0));
    pushCheck(10, 16'h0F0F, code(1));

    // R9 status byte first
    readFrame(cb(2'b01, 2'b00, 2'd1, 1'b1), 3, r0, r1, r2);
    pushCheck(9, 8'hBF, int'(r0));
    pushCheck(9, 16'h0F0F, int'({r1, r2}));
    readFrame(cb(2'b01, 2'b00, 2'd0, 1'b1), 3, r0, r1, r2);
    pushCheck(9, 8'h3F, int'(r0));

    // R8 two-byte read, load mode bits irrelevant
    readFrame(cb(2'b01, 2'b01, 2'd3, 1'b0), 2, r0, r1, r2);
    pushCheck(8, 16'h0F0F, int'({r0, r1}));

    // R11 rejected read stays released
    readFrame(cb(2'b11, 2'b00, 2'd1, 1'b1), 3, r0, r1, r2);
    pushCheck(11, 24'hFFFFFF, int'({r0, r1, r2}));

    // R12 stop before the last byte discards the write
    i2cStart; sendByte(8'h98, ak); sendByte(cb(2'b01, 2'b01, 2'd0, 1'b0), ak);
    sendByte(8'h12, ak); i2cStop; settle;
    pushCheck(12, 16'h0F0F, code(0));

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule